// File: doc/BRIEF.md
# Byte-to-Word IDE Data Bridge

This block lets an 8-bit host talk to a 16-bit IDE device. The host sees sixteen byte-wide locations selected by a 4-bit offset. Most offsets pass straight through to one task-file register or to the alternate-status/device-control register. Two offsets work as a pair so that a full data word can move as two byte accesses.

On a read of the data offset, the block runs one 16-bit device read. The host gets the low byte, and the high byte is kept in a read holding register that the data-high offset returns. For a write, the host first writes the data-high offset, which fills a separate write holding register. The next write to the data offset then sends the word made of that held byte and the new low byte.

Each device cycle follows a fixed sequence: address and chip select first, then a read or write strobe of programmable length, then a hold cycle. A busy output keeps the host from starting another access until the sequence is done. A build-time parameter picks one of two board wirings for the host offsets.

Top module: `ide_byte_bridge`

## Requirements
- R1: A host read at the data location starts one device read with chip select 0 and device address 0. The host receives bits 7:0 of the device word on `host_rdata` with `host_rvalid`, and bits 15:8 are stored in the read holding register.
- R2: A host read at the data-high location returns the read holding register one cycle later and starts no device cycle.
- R3: A host write at the data-high location only loads the write holding register and starts no device cycle.
- R4: A host write at the data location starts one device write with chip select 0 and device address 0. The driven word is {write holding register, host byte}.
- R5: With REV=1, offsets 1 to 7 reach chip select 0 with a device address equal to the offset, offset 8 is data-high, and offset 14 reaches chip select 1 with device address 6.
- R6: With REV=2, the map is: data at offset 0, data-high at 1, and device addresses 1 to 7 under chip select 0 at offsets 8, 2, 10, 4, 12, 6, 14 in that order. Offset 7 reaches chip select 1 with device address 6.
- R7: A host read of an unmapped offset returns 0x00 one cycle later. A host write to an unmapped offset starts no device cycle and changes neither holding register.
- R8: In every device cycle, chip select and address are asserted one cycle before the strobe goes low. The strobe stays low for exactly PULSE_CYC clocks. Only one of the two strobes and only one chip select are active at a time, and chip select and write data stay valid for one cycle after the strobe rises.
- R9: `host_busy` rises in the cycle after a device access is accepted and falls in the cycle where `host_rvalid` pulses for a read. Host strobes seen while busy is high are ignored.
- R10: After reset, both holding registers read 0x00, all chip selects and strobes are inactive (high), and `host_busy` is low.
- R11: A device read at a non-data location returns bits 7:0 to the host and leaves the read holding register unchanged. A device write at a non-data location drives {0x00, host byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Host byte offset |
| host_rd | input | 1 | One-cycle host read request |
| host_wr | input | 1 | One-cycle host write request |
| host_wdata | input | HB | Host write byte |
| host_rdata | output | HB | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read completion pulse |
| host_busy | output | 1 | Device cycle in progress; requests ignored |
| dev_cs0_n | output | 1 | Task-file chip select, active low |
| dev_cs1_n | output | 1 | Control-block chip select, active low |
| dev_da | output | 3 | Device register address |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| dev_dout | output | 2*HB | Word driven to the device |
| dev_doe | output | 1 | Drive enable for dev_dout |
| dev_din | input | 2*HB | Word returned by the device |

## Verification
The bench drives random sequences of reads and writes over all sixteen offsets on both the REV=1 and REV=2 builds, with random device words. This separates pass-through registers from the paired data offsets, and one board map from the other. Directed cases cover:
- a write pair followed by a read pair, where a swapped or shared holding register would show up;
- a data-high write issued while busy, which must not reach the next data write;
- unmapped accesses between paired accesses, which must leave both holding registers alone.

Device-cycle pulse length and setup are measured on every access.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_DATA  = 3'd1,
    ACC_DHIGH = 3'd2,
    ACC_TASK  = 3'd3,
    ACC_CTRL  = 3'd4
  } acc_kind_t;

  typedef struct packed {
    acc_kind_t  kind;
    logic       ctrl_blk;
    logic [2:0] da;
  } acc_decode_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_STROBE = 2'd2,
    SQ_HOLD   = 2'd3
  } seq_state_t;

  localparam logic [2:0] DATA_DA = 3'd0;
  localparam logic [2:0] CTRL_DA = 3'd6;

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_bridge_pkg::*;
#(
  parameter int REV = 1
) (
  input  logic [3:0]  addr,
  output acc_decode_t dec
);

  logic [3:0] canon;

  // Board revision 2 wires host address bits 0 and 3 crossed.
  generate
    if (REV == 2) begin : g_rev2
      assign canon = {addr[0], addr[2:1], addr[3]};
    end else begin : g_rev1
      assign canon = addr;
    end
  endgenerate

  always_comb begin
    dec.kind     = ACC_NONE;
    dec.ctrl_blk = 1'b0;
    dec.da       = DATA_DA;
    if (canon == 4'd0) begin
      dec.kind = ACC_DATA;
    end else if (!canon[3]) begin
      dec.kind = ACC_TASK;
      dec.da   = canon[2:0];
    end else if (canon == 4'd8) begin
      dec.kind = ACC_DHIGH;
    end else if (canon == 4'd14) begin
      dec.kind     = ACC_CTRL;
      dec.ctrl_blk = 1'b1;
      dec.da       = CTRL_DA;
    end
  end

endmodule

// File: rtl/ide_byte_latches.sv
module ide_byte_latches #(
  parameter int HB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_load,
  input  logic [HB-1:0] rd_in,
  input  logic          wr_load,
  input  logic [HB-1:0] wr_in,
  output logic [HB-1:0] rd_q,
  output logic [HB-1:0] wr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (rd_load) rd_q <= rd_in;
      if (wr_load) wr_q <= wr_in;
    end
  end

endmodule

// File: rtl/ide_dev_sequencer.sv
module ide_dev_sequencer
  import ide_bridge_pkg::*;
#(
  parameter int PULSE_CYC = 3,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_wr,
  input  logic          start_ctrl,
  input  logic [2:0]    start_da,
  input  logic [DW-1:0] start_wdata,
  input  logic [DW-1:0] dev_din,
  output logic          dev_cs0_n,
  output logic          dev_cs1_n,
  output logic [2:0]    dev_da,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic [DW-1:0] dev_dout,
  output logic          dev_doe,
  output logic          busy,
  output logic          cap_valid,
  output logic [DW-1:0] cap_word
);

  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic          op_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      cnt       <= '0;
      op_wr     <= 1'b0;
      dev_cs0_n <= 1'b1;
      dev_cs1_n <= 1'b1;
      dev_da    <= '0;
      dev_rd_n  <= 1'b1;
      dev_wr_n  <= 1'b1;
      dev_dout  <= '0;
      dev_doe   <= 1'b0;
      cap_valid <= 1'b0;
      cap_word  <= '0;
    end else begin
      cap_valid <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            st        <= SQ_SETUP;
            op_wr     <= start_wr;
            dev_cs0_n <= start_ctrl;
            dev_cs1_n <= !start_ctrl;
            dev_da    <= start_da;
            dev_dout  <= start_wr ? start_wdata : '0;
            dev_doe   <= start_wr;
          end
        end
        SQ_SETUP: begin
          st       <= SQ_STROBE;
          cnt      <= '0;
          dev_rd_n <= op_wr;
          dev_wr_n <= !op_wr;
        end
        SQ_STROBE: begin
          if (cnt == LAST) begin
            st       <= SQ_HOLD;
            dev_rd_n <= 1'b1;
            dev_wr_n <= 1'b1;
            if (!op_wr) begin
              cap_word  <= dev_din;
              cap_valid <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_HOLD: begin
          st        <= SQ_IDLE;
          dev_cs0_n <= 1'b1;
          dev_cs1_n <= 1'b1;
          dev_doe   <= 1'b0;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (st != SQ_IDLE);

endmodule

// File: rtl/ide_byte_bridge.sv
module ide_byte_bridge
  import ide_bridge_pkg::*;
#(
  parameter int REV       = 1,
  parameter int PULSE_CYC = 3,
  parameter int HB        = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      host_addr,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [HB-1:0]   host_wdata,
  output logic [HB-1:0]   host_rdata,
  output logic            host_rvalid,
  output logic            host_busy,
  output logic            dev_cs0_n,
  output logic            dev_cs1_n,
  output logic [2:0]      dev_da,
  output logic            dev_rd_n,
  output logic            dev_wr_n,
  output logic [2*HB-1:0] dev_dout,
  output logic            dev_doe,
  input  logic [2*HB-1:0] dev_din
);

  localparam int DW = 2 * HB;

  acc_decode_t   dec;
  logic          busy;
  logic          accept;
  logic          is_dev;
  logic          dev_start;
  logic          pend_data;
  logic          cap_valid;
  logic [DW-1:0] cap_word;
  logic [DW-1:0] start_word;
  logic [HB-1:0] rlat_q;
  logic [HB-1:0] wlat_q;

  ide_addr_decode #(.REV(REV)) u_dec (
    .addr (host_addr),
    .dec  (dec)
  );

  assign accept     = !busy && (host_rd ^ host_wr);
  assign is_dev     = (dec.kind == ACC_DATA) || (dec.kind == ACC_TASK) ||
                      (dec.kind == ACC_CTRL);
  assign dev_start  = accept && is_dev;
  assign start_word = (dec.kind == ACC_DATA) ? {wlat_q, host_wdata}
                                             : {{HB{1'b0}}, host_wdata};

  ide_byte_latches #(.HB(HB)) u_lat (
    .clk     (clk),
    .rst     (rst),
    .rd_load (cap_valid && pend_data),
    .rd_in   (cap_word[DW-1:HB]),
    .wr_load (accept && host_wr && (dec.kind == ACC_DHIGH)),
    .wr_in   (host_wdata),
    .rd_q    (rlat_q),
    .wr_q    (wlat_q)
  );

  ide_dev_sequencer #(.PULSE_CYC(PULSE_CYC), .DW(DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (dev_start),
    .start_wr    (host_wr),
    .start_ctrl  (dec.ctrl_blk),
    .start_da    (dec.da),
    .start_wdata (start_word),
    .dev_din     (dev_din),
    .dev_cs0_n   (dev_cs0_n),
    .dev_cs1_n   (dev_cs1_n),
    .dev_da      (dev_da),
    .dev_rd_n    (dev_rd_n),
    .dev_wr_n    (dev_wr_n),
    .dev_dout    (dev_dout),
    .dev_doe     (dev_doe),
    .busy        (busy),
    .cap_valid   (cap_valid),
    .cap_word    (cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_data   <= 1'b0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      if (dev_start) pend_data <= host_rd && (dec.kind == ACC_DATA);
      if (cap_valid) begin
        host_rdata  <= cap_word[HB-1:0];
        host_rvalid <= 1'b1;
      end else if (accept && host_rd && !is_dev) begin
        host_rdata  <= (dec.kind == ACC_DHIGH) ? rlat_q : '0;
        host_rvalid <= 1'b1;
      end
    end
  end

  assign host_busy = busy;

endmodule

// File: rtl/ide_byte_bridge_chk.sv
module ide_byte_bridge_chk #(
  parameter int PULSE_CYC = 3,
  parameter int HB        = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            host_busy,
  input logic            host_rvalid,
  input logic            dev_cs0_n,
  input logic            dev_cs1_n,
  input logic [2:0]      dev_da,
  input logic            dev_rd_n,
  input logic            dev_wr_n,
  input logic [2*HB-1:0] dev_dout,
  input logic            dev_doe
);

  localparam int LW = $clog2(PULSE_CYC + 2) + 1;

  logic          strobe_low;
  logic          cs_any;
  logic [LW-1:0] low_cnt;

  assign strobe_low = !dev_rd_n || !dev_wr_n;
  assign cs_any     = !dev_cs0_n || !dev_cs1_n;

  always_ff @(posedge clk) begin
    if (rst)             low_cnt <= '0;
    else if (strobe_low) low_cnt <= low_cnt + 1'b1;
    else                 low_cnt <= '0;
  end

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !(!dev_rd_n && !dev_wr_n));

  assert_one_select_R8: assert property (@(posedge clk) disable iff (rst)
    strobe_low |-> (dev_cs0_n ^ dev_cs1_n));

  assert_setup_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_low) |-> ($past(cs_any) && $stable(dev_da)));

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_low) |-> (low_cnt == LW'(PULSE_CYC)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_low) |-> (cs_any && $stable(dev_da)));

  assert_wr_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_wr_n) |-> (dev_doe && $stable(dev_dout)));

  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (rst)
    strobe_low |-> host_busy);

  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> !host_busy);

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && !host_busy && !dev_doe));

endmodule

bind ide_byte_bridge ide_byte_bridge_chk #(.PULSE_CYC(PULSE_CYC), .HB(HB)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_busy   (host_busy),
  .host_rvalid (host_rvalid),
  .dev_cs0_n   (dev_cs0_n),
  .dev_cs1_n   (dev_cs1_n),
  .dev_da      (dev_da),
  .dev_rd_n    (dev_rd_n),
  .dev_wr_n    (dev_wr_n),
  .dev_dout    (dev_dout),
  .dev_doe     (dev_doe)
);

// File: tb/ide_byte_bridge_bench.sv
`timescale 1ns/1ps
module ide_byte_bridge_bench;

  localparam int PULSE = 3;
  localparam int K_NONE = 0, K_DATA = 1, K_DHIGH = 2, K_TASK = 3, K_CTRL = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] dev_din = '0;
  int          sel = 0;

  logic [7:0]  rdata_a, rdata_b;
  logic        rv_a, rv_b, busy_a, busy_b;
  logic        cs0_a, cs0_b, cs1_a, cs1_b, rdn_a, rdn_b, wrn_a, wrn_b, doe_a, doe_b;
  logic [2:0]  da_a, da_b;
  logic [15:0] dout_a, dout_b;

  always #2.5 clk = !clk;

  ide_byte_bridge #(.REV(1), .PULSE_CYC(PULSE)) u_ide_byte_bridge (
    .clk(clk), .rst(rst), .host_addr(host_addr),
    .host_rd(host_rd && sel == 0), .host_wr(host_wr && sel == 0),
    .host_wdata(host_wdata), .host_rdata(rdata_a), .host_rvalid(rv_a),
    .host_busy(busy_a), .dev_cs0_n(cs0_a), .dev_cs1_n(cs1_a), .dev_da(da_a),
    .dev_rd_n(rdn_a), .dev_wr_n(wrn_a), .dev_dout(dout_a), .dev_doe(doe_a),
    .dev_din(dev_din));

  ide_byte_bridge #(.REV(2), .PULSE_CYC(PULSE)) u_ide_byte_bridge_r2 (
    .clk(clk), .rst(rst), .host_addr(host_addr),
    .host_rd(host_rd && sel == 1), .host_wr(host_wr && sel == 1),
    .host_wdata(host_wdata), .host_rdata(rdata_b), .host_rvalid(rv_b),
    .host_busy(busy_b), .dev_cs0_n(cs0_b), .dev_cs1_n(cs1_b), .dev_da(da_b),
    .dev_rd_n(rdn_b), .dev_wr_n(wrn_b), .dev_dout(dout_b), .dev_doe(doe_b),
    .dev_din(dev_din));

  wire        m_busy = (sel == 1) ? busy_b : busy_a;
  wire        m_rdn  = rdn_a & rdn_b;
  wire        m_wrn  = wrn_a & wrn_b;
  wire        m_cs0  = cs0_a & cs0_b;
  wire        m_cs1  = cs1_a & cs1_b;
  wire [2:0]  m_da   = (sel == 1) ? da_b : da_a;
  wire [15:0] m_dout = (sel == 1) ? dout_b : dout_a;

  int n_tests = 0, n_fail = 0;
  int acc_cnt = 0, rv_cnt = 0, low_len = 0, last_len = 0;
  bit prev_low = 0, prev_cs = 0, setup_ok = 0, a_wr = 0, a_cs1 = 0, a_cs0 = 0;
  logic [2:0]  a_da = '0;
  logic [15:0] a_dout = '0;
  logic [7:0]  rv_data = '0;
  logic [7:0]  m_rlat [2];
  logic [7:0]  m_wlat [2];

  // Passive monitor of the device pins and the host read return.
  always @(posedge clk) begin
    bit lo;
    lo = !m_rdn || !m_wrn;
    if (lo && !prev_low) begin
      acc_cnt++;
      a_wr = !m_wrn; a_cs0 = !m_cs0; a_cs1 = !m_cs1;
      a_da = m_da; a_dout = m_dout; setup_ok = prev_cs;
    end
    if (lo) low_len++;
    else if (prev_low) begin last_len = low_len; low_len = 0; end
    prev_low = lo;
    prev_cs  = !m_cs0 || !m_cs1;
    if (rv_a || rv_b) begin
      rv_cnt++;
      rv_data = rv_a ? rdata_a : rdata_b;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected map taken from R5 / R6 (kind, chip-select-1 flag, address).
  function automatic int ekind(input int rev, input logic [3:0] a);
    if (rev == 1) begin
      if (a == 0) return K_DATA;
      if (a < 8) return K_TASK;
      if (a == 8) return K_DHIGH;
      if (a == 14) return K_CTRL;
      return K_NONE;
    end
    case (a)
      4'd0: return K_DATA;
      4'd1: return K_DHIGH;
      4'd8, 4'd2, 4'd10, 4'd4, 4'd12, 4'd6, 4'd14: return K_TASK;
      4'd7: return K_CTRL;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic [2:0] eda(input int rev, input logic [3:0] a);
    if (ekind(rev, a) == K_CTRL) return 3'd6;
    if (rev == 1) return a[2:0];
    case (a)
      4'd8: return 3'd1;  4'd2: return 3'd2;  4'd10: return 3'd3;
      4'd4: return 3'd4;  4'd12: return 3'd5; 4'd6: return 3'd6;
      4'd14: return 3'd7; default: return 3'd0;
    endcase
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic access(input int s, input bit wr, input logic [3:0] a,
                        input logic [7:0] b, input logic [15:0] din, input string tag);
    int k, pa, pr;
    k = ekind(s + 1, a);
    sel = s;
    wait_idle();
    dev_din = din;
    pa = acc_cnt; pr = rv_cnt;
    host_addr = a; host_wdata = b; host_rd = !wr; host_wr = wr;
    @(negedge clk);
    host_rd = 0; host_wr = 0;
    wait_idle();
    @(negedge clk);
    if (k == K_DATA || k == K_TASK || k == K_CTRL) begin
      chk({tag, " dev access count"}, acc_cnt, pa + 1);
      chk({tag, " dev dir"}, a_wr, wr);
      chk({tag, " dev cs1"}, {a_cs1, a_cs0}, (k == K_CTRL) ? 2'b10 : 2'b01);
      chk({tag, " dev addr"}, a_da, (k == K_DATA) ? 3'd0 : eda(s + 1, a));
      chk({tag, " R8 pulse"}, last_len, PULSE);
      chk({tag, " R8 setup"}, setup_ok, 1);
      if (wr)
        chk({tag, " dev word"}, a_dout, (k == K_DATA) ? {m_wlat[s], b} : {8'h00, b});
      else begin
        chk({tag, " rvalid"}, rv_cnt, pr + 1);
        chk({tag, " rdata"}, rv_data, din[7:0]);
        if (k == K_DATA) m_rlat[s] = din[15:8];
      end
    end else begin
      chk({tag, " no dev access"}, acc_cnt, pa);
      if (!wr) begin
        chk({tag, " rvalid"}, rv_cnt, pr + 1);
        chk({tag, " rdata"}, rv_data, (k == K_DHIGH) ? m_rlat[s] : 8'h00);
      end else begin
        chk({tag, " no rvalid"}, rv_cnt, pr);
        if (k == K_DHIGH) m_wlat[s] = b;
      end
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int pa;
    void'($urandom(32'd4242));
    m_rlat[0] = 0; m_rlat[1] = 0; m_wlat[0] = 0; m_wlat[1] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state on pins
    chk("R10 pins idle", {m_cs0, m_cs1, m_rdn, m_wrn, busy_a, busy_b}, 6'b111100);
    // R10 latches cleared: data-high read, then data write shows zero high byte
    access(0, 0, 4'd8, 8'h00, 16'h0000, "R10 R2 rlatch reset");
    access(0, 1, 4'd0, 8'h3C, 16'h0000, "R10 R4 wlatch reset");
    // R3/R4 paired write; R1/R2 paired read
    access(0, 1, 4'd8, 8'hA5, 16'h0000, "R3 dhigh write");
    access(0, 1, 4'd0, 8'h5A, 16'h0000, "R4 data write");
    access(0, 0, 4'd0, 8'h00, 16'hBEEF, "R1 data read");
    access(0, 0, 4'd8, 8'h00, 16'h1111, "R2 dhigh read");
    // R11 task read keeps latch, R5 control block
    access(0, 0, 4'd3, 8'h00, 16'hCAFE, "R11 R5 task read");
    access(0, 0, 4'd8, 8'h00, 16'h0000, "R11 latch kept");
    access(0, 1, 4'd14, 8'h77, 16'h0000, "R5 R11 ctrl write");
    access(0, 0, 4'd14, 8'h00, 16'h9876, "R5 ctrl read");
    // R7 unmapped
    access(0, 1, 4'd9, 8'hEE, 16'h0000, "R7 unmapped write");
    access(0, 0, 4'd11, 8'h00, 16'hFFFF, "R7 unmapped read");
    access(0, 0, 4'd8, 8'h00, 16'h0000, "R7 rlatch kept");
    access(0, 1, 4'd0, 8'h01, 16'h0000, "R7 wlatch kept");
    // R6 revision-2 map
    access(1, 1, 4'd1, 8'h42, 16'h0000, "R6 dhigh write");
    access(1, 1, 4'd0, 8'h24, 16'h0000, "R6 data write");
    access(1, 0, 4'd7, 8'h00, 16'h1357, "R6 ctrl read");
    access(1, 0, 4'd10, 8'h00, 16'h2468, "R6 task read");
    access(1, 0, 4'd9, 8'h00, 16'h0000, "R6 R7 unmapped read");
    // R9 request while busy is ignored
    sel = 0;
    wait_idle();
    host_addr = 4'd0; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    chk("R9 busy after accept", m_busy, 1);
    pa = acc_cnt;
    host_addr = 4'd8; host_wdata = 8'hC3; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    wait_idle();
    @(negedge clk);
    chk("R9 single dev access", acc_cnt, pa + 1);
    m_rlat[0] = dev_din[15:8];
    access(0, 1, 4'd0, 8'h11, 16'h0000, "R9 ignored write");
    // Random mix on both revisions
    for (int i = 0; i < 400; i++) begin
      access(int'($urandom_range(1, 0)), bit'($urandom_range(1, 0)),
             4'($urandom_range(15, 0)), 8'($urandom), 16'($urandom), "rand");
    end
    report();
  end

endmodule